// File: doc/BRIEF.md
# Time-Multiplexed Matrix Mixer

This block mixes a beat of NI input samples into a beat of NO output samples. Each output channel is the weighted sum of all input channels. The weights form an NI by NO coefficient matrix. A single multiply-accumulate stage works through every product in turn, so the block trades throughput for area. A mix takes exactly NI*NO cycles.

The coefficients sit in a register bank. The bank is loaded at reset from a build-time parameter; the default is a unit diagonal. An optional update stream can rewrite one coefficient per beat at run time. It accepts a beat only while the mixer is idle, so every output array is computed with a single consistent coefficient set. All three streams use a valid/ready handshake.

Top module: `mtx_mix`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and upd_ready is 1 when UPD_EN=1.
- R2: Samples are signed Q1.15 and coefficients are signed Q2.14 (0x4000 means 1.0). Input channel k sits at in_data[k*SW +: SW] and output channel k at out_data[k*SW +: SW]. Output channel o equals floor((sum over i of x[i]*c[i][o]) / 2^14), computed without overflow in the accumulator.
- R3: A result above 32767 is driven out as 32767, and a result below -32768 is driven out as -32768.
- R4: out_valid rises exactly NI*NO clock cycles after the edge at which an input beat is accepted.
- R5: While out_valid is 1 and out_ready is 0, out_data stays stable and in_ready stays 0. After the output handshake the block is idle again and in_ready is 1.
- R6: With the default COEF_INIT, c[i][o] is 1.0 when i equals o and 0 otherwise, so with NI=NO the output equals the input.
- R7: An update beat accepted with upd_valid and upd_ready writes upd_val into c[upd_in][upd_out]. Later mixes use the new value and leave every other coefficient unchanged.
- R8: upd_ready is 0 from the accepting edge of an input beat until its output handshake completes, so an update offered mid-mix does not affect that mix. An update accepted in the same cycle as an input beat applies to that beat.
- R9: When UPD_EN=0, upd_ready is held at 0 and the coefficients keep their initial values whatever the update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample array valid |
| in_ready | output | 1 | Mixer idle, ready for an input array |
| in_data | input | NI*SW | Input samples, channel k at bits k*SW |
| out_valid | output | 1 | Output array valid |
| out_ready | input | 1 | Consumer accepts the output array |
| out_data | output | NO*SW | Output samples, channel k at bits k*SW |
| upd_valid | input | 1 | Coefficient update beat valid |
| upd_ready | output | 1 | Coefficient update accepted this cycle |
| upd_out | input | OXW | Output channel index of the coefficient |
| upd_in | input | IXW | Input channel index of the coefficient |
| upd_val | input | CW | New coefficient value, signed Q2.14 |

## Verification
Some properties hold on every cycle and are checked by assertions:
- the fixed NI*NO latency from input acceptance to out_valid, measured with a counter in the checker;
- a stable held output beat;
- the mutual exclusion of in_ready with out_valid;
- the update port staying closed while a mix is in flight, or for good when UPD_EN=0.

The arithmetic can only be shown by the bench's sweeps, which compare the outputs with a sum-of-products model:
- floor scaling;
- saturation at both rails;
- the effect of each coefficient write;
- whether a held-off update reaches the mix it was offered during or only the one after it.

// File: rtl/mix_pkg.sv
`timescale 1ns/1ps
package mix_pkg;

  typedef enum logic [1:0] {
    MX_IDLE = 2'd0,
    MX_RUN  = 2'd1,
    MX_SEND = 2'd2
  } mix_state_e;

  // Unit-diagonal matrix, entry (i,o) at bit offset (i*no+o)*cw, value 2^frac.
  function automatic logic [4095:0] unit_diag(int ni, int no, int cw, int frac);
    logic [4095:0] v;
    v = '0;
    for (int i = 0; i < ni; i++) begin
      for (int o = 0; o < no; o++) begin
        for (int b = 0; b < cw; b++) begin
          if (((i * no + o) * cw + b) < 4096)
            v[(i * no + o) * cw + b] = (i == o) && (b == frac);
        end
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/mix_coef_bank.sv
`timescale 1ns/1ps
module mix_coef_bank #(
  parameter int NI = 4,
  parameter int NO = 4,
  parameter int CW = 16,
  parameter bit UPD_EN = 1'b1,
  parameter logic [NI*NO*CW-1:0] INIT = '0,
  localparam int IXW = (NI > 1) ? $clog2(NI) : 1,
  localparam int OXW = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IXW-1:0] wr_in,
  input  logic [OXW-1:0] wr_out,
  input  logic [CW-1:0]  wr_val,
  input  logic [IXW-1:0] rd_in,
  input  logic [OXW-1:0] rd_out,
  output logic [CW-1:0]  rd_val
);
  localparam int NC = NI * NO;

  logic [CW-1:0] coef_q [NC];

  assign rd_val = coef_q[int'(rd_in) * NO + int'(rd_out)];

  generate
    if (UPD_EN) begin : g_upd
      logic in_ok;
      assign in_ok = ({1'b0, wr_in} < (IXW+1)'(NI)) && ({1'b0, wr_out} < (OXW+1)'(NO));
      for (genvar a = 0; a < NC; a++) begin : g_cell
        logic hit;
        assign hit = wr_en && in_ok && ((int'(wr_in) * NO + int'(wr_out)) == a);
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   coef_q[a] <= INIT[a*CW +: CW];
          else if (hit) coef_q[a] <= wr_val;
        end
      end
    end else begin : g_fixed
      logic unused_wr;
      assign unused_wr = ^{wr_en, wr_in, wr_out, wr_val};
      for (genvar a = 0; a < NC; a++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) coef_q[a] <= INIT[a*CW +: CW];
          else        coef_q[a] <= coef_q[a];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/mix_mac.sv
`timescale 1ns/1ps
module mix_mac #(
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int CFRAC = 14,
  parameter int NI = 4,
  localparam int LOGI = (NI > 1) ? $clog2(NI) : 0,
  localparam int PW = SW + CW,
  localparam int ACCW = PW + LOGI
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [SW-1:0] samp,
  input  logic [CW-1:0] coef,
  output logic [SW-1:0] sat_out
);
  localparam int SMAXI = (1 << (SW - 1)) - 1;
  localparam logic signed [ACCW-1:0] SMAX = ACCW'(SMAXI);
  localparam logic signed [ACCW-1:0] SMIN = ACCW'(-SMAXI - 1);

  logic signed [SW-1:0]   samp_s;
  logic signed [CW-1:0]   coef_s;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_ext;
  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] acc_nx;
  logic signed [ACCW-1:0] scaled;

  always_comb begin
    samp_s   = samp;
    coef_s   = coef;
    prod     = samp_s * coef_s;
    prod_ext = ACCW'(prod);
    acc_nx   = (clr ? '0 : acc_q) + prod_ext;
    scaled   = acc_nx >>> CFRAC;
    if (scaled > SMAX)      sat_out = SMAX[SW-1:0];
    else if (scaled < SMIN) sat_out = SMIN[SW-1:0];
    else                    sat_out = scaled[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_nx;
  end

endmodule

// File: rtl/mix_ctrl.sv
`timescale 1ns/1ps
module mix_ctrl #(
  parameter int NI = 4,
  parameter int NO = 4,
  localparam int IXW = (NI > 1) ? $clog2(NI) : 1,
  localparam int OXW = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           out_ready,
  output logic           idle,
  output logic           take,
  output logic           run,
  output logic           first_term,
  output logic           last_term,
  output logic [IXW-1:0] term_i,
  output logic [OXW-1:0] term_o,
  output logic           send
);
  import mix_pkg::*;

  mix_state_e st_q, st_nx;
  logic [IXW-1:0] ii_q, ii_nx;
  logic [OXW-1:0] oi_q, oi_nx;
  logic           adv;

  assign idle       = (st_q == MX_IDLE);
  assign run        = (st_q == MX_RUN);
  assign send       = (st_q == MX_SEND);
  assign take       = idle && in_valid;
  assign term_i     = ii_q;
  assign term_o     = oi_q;
  assign first_term = (ii_q == '0);
  assign last_term  = (ii_q == IXW'(NI - 1));

  always_comb begin
    st_nx = st_q;
    ii_nx = ii_q;
    oi_nx = oi_q;
    unique case (st_q)
      MX_IDLE: if (in_valid) begin
        st_nx = MX_RUN;
        ii_nx = '0;
        oi_nx = '0;
      end
      MX_RUN: begin
        if (last_term) begin
          ii_nx = '0;
          if (oi_q == OXW'(NO - 1)) st_nx = MX_SEND;
          else                      oi_nx = oi_q + 1'b1;
        end else begin
          ii_nx = ii_q + 1'b1;
        end
      end
      MX_SEND: if (out_ready) st_nx = MX_IDLE;
      default: st_nx = MX_IDLE;
    endcase
  end

  assign adv = take || run || (send && out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MX_IDLE;
      ii_q <= '0;
      oi_q <= '0;
    end else if (adv) begin
      st_q <= st_nx;
      ii_q <= ii_nx;
      oi_q <= oi_nx;
    end
  end

endmodule

// File: rtl/mtx_mix.sv
`timescale 1ns/1ps
module mtx_mix #(
  parameter int NI = 4,
  parameter int NO = 4,
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int CFRAC = 14,
  parameter bit UPD_EN = 1'b1,
  parameter logic [NI*NO*CW-1:0] COEF_INIT =
    (NI*NO*CW)'(mix_pkg::unit_diag(NI, NO, CW, CFRAC)),
  localparam int IXW = (NI > 1) ? $clog2(NI) : 1,
  localparam int OXW = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NI*SW-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NO*SW-1:0] out_data,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [OXW-1:0]   upd_out,
  input  logic [IXW-1:0]   upd_in,
  input  logic [CW-1:0]    upd_val
);
  logic           idle, take, run, first_term, last_term, send;
  logic [IXW-1:0] term_i;
  logic [OXW-1:0] term_o;
  logic [CW-1:0]  coef_rd;
  logic [SW-1:0]  sat_val;
  logic [SW-1:0]  samp_q [NI];
  logic [SW-1:0]  obuf_q [NO];
  logic           upd_wr;

  mix_ctrl #(.NI(NI), .NO(NO)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .idle(idle), .take(take), .run(run), .first_term(first_term),
    .last_term(last_term), .term_i(term_i), .term_o(term_o), .send(send)
  );

  assign in_ready  = idle;
  assign out_valid = send;
  assign upd_ready = UPD_EN && idle;
  assign upd_wr    = upd_valid && upd_ready;

  mix_coef_bank #(.NI(NI), .NO(NO), .CW(CW), .UPD_EN(UPD_EN), .INIT(COEF_INIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(upd_wr), .wr_in(upd_in), .wr_out(upd_out),
    .wr_val(upd_val), .rd_in(term_i), .rd_out(term_o), .rd_val(coef_rd)
  );

  mix_mac #(.SW(SW), .CW(CW), .CFRAC(CFRAC), .NI(NI)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(run), .clr(first_term),
    .samp(samp_q[term_i]), .coef(coef_rd), .sat_out(sat_val)
  );

  generate
    for (genvar k = 0; k < NI; k++) begin : g_samp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    samp_q[k] <= '0;
        else if (take) samp_q[k] <= in_data[k*SW +: SW];
      end
    end
    for (genvar k = 0; k < NO; k++) begin : g_obuf
      logic wr_k;
      assign wr_k = run && last_term && (term_o == OXW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    obuf_q[k] <= '0;
        else if (wr_k) obuf_q[k] <= sat_val;
      end
      assign out_data[k*SW +: SW] = obuf_q[k];
    end
  endgenerate

endmodule

// File: rtl/mtx_mix_chk.sv
`timescale 1ns/1ps
module mtx_mix_chk #(
  parameter int NI = 4,
  parameter int NO = 4,
  parameter int SW = 16,
  parameter bit UPD_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NO*SW-1:0] out_data,
  input logic             upd_ready
);
  localparam int LAT = NI * NO;

  int lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lat_cnt <= 0;
    else if (in_valid && in_ready)  lat_cnt <= 0;
    else if (!out_valid && lat_cnt < LAT + 2) lat_cnt <= lat_cnt + 1;
  end

  // R4
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == LAT));

  // R5
  held_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  no_in_during_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8
  upd_closed_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !upd_ready);

  generate
    if (!UPD_EN) begin : g_fixed
      // R9
      upd_never_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !upd_ready);
    end
  endgenerate

endmodule

bind mtx_mix mtx_mix_chk #(.NI(NI), .NO(NO), .SW(SW), .UPD_EN(UPD_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .upd_ready(upd_ready)
);

// File: tb/tb_mtx_mix.sv
`timescale 1ns/1ps
module tb_mtx_mix;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int SW = 16;
  localparam int CW = 16;
  localparam int IXW = 2;
  localparam int OXW = 2;

  logic clk, rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [NI*SW-1:0] in_data;
  logic [NO*SW-1:0] out_data;
  logic upd_valid, upd_ready;
  logic [OXW-1:0] upd_out;
  logic [IXW-1:0] upd_in;
  logic [CW-1:0] upd_val;

  logic f_in_valid, f_in_ready, f_out_valid, f_out_ready, f_upd_ready;
  logic [NO*SW-1:0] f_out_data;

  int n_chk, n_fail;
  bit done;
  int cm [NI][NO];
  int xv [NI];
  logic [31:0] rng;

  mtx_mix #(.NI(NI), .NO(NO), .SW(SW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_out(upd_out), .upd_in(upd_in), .upd_val(upd_val)
  );

  mtx_mix #(.NI(NI), .NO(NO), .SW(SW), .CW(CW), .UPD_EN(1'b0)) dut_fixed (
    .clk(clk), .rst_n(rst_n), .in_valid(f_in_valid), .in_ready(f_in_ready),
    .in_data(in_data), .out_valid(f_out_valid), .out_ready(f_out_ready),
    .out_data(f_out_data), .upd_valid(upd_valid), .upd_ready(f_upd_ready),
    .upd_out(upd_out), .upd_in(upd_in), .upd_val(upd_val)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  function automatic int expect_ch(input int o);
    longint s;
    s = 0;
    for (int i = 0; i < NI; i++) s += longint'(xv[i]) * longint'(cm[i][o]);
    s = s >>> 14;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  function automatic int get_out(input logic [NO*SW-1:0] d, input int o);
    return int'($signed(d[o*SW +: SW]));
  endfunction

  task automatic drive_x();
    for (int k = 0; k < NI; k++) in_data[k*SW +: SW] = SW'(xv[k]);
  endtask

  task automatic set_coef(input int i, input int o, input int v);
    @(negedge clk);
    chk("R7 upd_ready idle", upd_ready, 1);
    upd_in = IXW'(i); upd_out = OXW'(o); upd_val = CW'(v); upd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    cm[i][o] = v;
  endtask

  // mode 0 plain, 1 update with input same cycle, 2 update offered mid-mix
  task automatic run_mix(input string req, input int stall, input int mode,
                         input int ui, input int uo, input int uv);
    int lat;
    int expv [NO];
    logic [NO*SW-1:0] held;
    @(negedge clk);
    chk({req, " R5 in_ready idle"}, in_ready, 1);
    drive_x();
    in_valid = 1'b1;
    if (mode != 0) begin
      upd_in = IXW'(ui); upd_out = OXW'(uo); upd_val = CW'(uv);
    end
    if (mode == 1) begin
      chk("R8 upd_ready with input", upd_ready, 1);
      upd_valid = 1'b1;
      cm[ui][uo] = uv;
    end
    for (int o = 0; o < NO; o++) expv[o] = expect_ch(o);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    upd_valid = (mode == 2);
    lat = 0;
    while (!out_valid && lat < 100) begin
      if (mode == 2) chk("R8 upd_ready busy", upd_ready, 0);
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    chk({req, " R4 latency"}, lat, NI * NO);
    for (int o = 0; o < NO; o++) chk(req, get_out(out_data, o), expv[o]);
    held = out_data;
    for (int s = 0; s < stall; s++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R5 out held valid", out_valid, 1);
      chk("R5 out held data", out_data, held);
      chk("R5 in_ready low", in_ready, 0);
      if (mode == 2) chk("R8 upd_ready held", upd_ready, 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R5 out_valid drops", out_valid, 0);
    chk("R5 in_ready returns", in_ready, 1);
    if (mode == 2) begin
      chk("R8 upd_ready after mix", upd_ready, 1);
      @(posedge clk);
      @(negedge clk);
      upd_valid = 1'b0;
      cm[ui][uo] = uv;
    end
    if (mode == 1) upd_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; rng = 32'h1234_5677;
    rst_n = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    upd_valid = 1'b0; upd_in = '0; upd_out = '0; upd_val = '0;
    f_in_valid = 1'b0; f_out_ready = 1'b0;
    for (int i = 0; i < NI; i++)
      for (int o = 0; o < NO; o++) cm[i][o] = (i == o) ? 16384 : 0;
    #9;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 upd_ready", upd_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 default unit diagonal
    xv = '{1000, -2000, 32767, -32768};
    run_mix("R6 unit", 0, 0, 0, 0, 0);
    xv = '{-1, 1, 0, 12345};
    run_mix("R6 unit", 2, 0, 0, 0, 0);

    // R9 fixed-coefficient variant ignores update beats
    @(negedge clk);
    upd_in = 2'd0; upd_out = 2'd0; upd_val = 16'h0000; upd_valid = 1'b1;
    chk("R9 upd_ready", f_upd_ready, 0);
    @(posedge clk);
    @(negedge clk);
    xv = '{700, -800, 900, -1000};
    drive_x();
    f_in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    f_in_valid = 1'b0;
    upd_valid = 1'b0;
    for (int w = 0; w < 40 && !f_out_valid; w++) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk("R9 out_valid", f_out_valid, 1);
    for (int o = 0; o < NO; o++) chk("R9 coefficients kept", get_out(f_out_data, o), xv[o]);
    f_out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    f_out_ready = 1'b0;

    // R7 load a full matrix
    for (int i = 0; i < NI; i++)
      for (int o = 0; o < NO; o++) begin
        rng = nxt(rng);
        set_coef(i, o, int'($signed(rng[15:0])) >>> 2);
      end

    // R2 sweep of input vectors
    for (int n = 0; n < 150; n++) begin
      for (int k = 0; k < NI; k++) begin
        rng = nxt(rng);
        xv[k] = int'($signed(rng[15:0]));
      end
      run_mix("R2 mix", n % 3, 0, 0, 0, 0);
    end

    // R7 single write leaves others alone
    set_coef(2, 1, -16384);
    xv = '{3000, 3000, 3000, 3000};
    run_mix("R7 single write", 0, 0, 0, 0, 0);

    // R3 saturation at both rails
    for (int i = 0; i < NI; i++)
      for (int o = 0; o < NO; o++) set_coef(i, o, (o == 3) ? -32768 : 32767);
    xv = '{32767, 32767, 32767, 32767};
    run_mix("R3 saturate", 1, 0, 0, 0, 0);
    xv = '{-32768, -32768, -32768, -32768};
    run_mix("R3 saturate", 0, 0, 0, 0, 0);
    xv = '{-32768, 0, 0, 0};
    run_mix("R3 near rail", 0, 0, 0, 0, 0);

    // R8 update together with input, then update held off mid-mix
    xv = '{1000, 2000, -3000, 4000};
    run_mix("R8 same cycle", 0, 1, 1, 0, 8192);
    run_mix("R8 held update", 2, 2, 0, 2, -4096);
    run_mix("R8 after held update", 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule